// File: doc/BRIEF.md
# Serial Command-Register Port for a Three-Channel Line Retimer

This block is the control port of a multi-channel line retimer. An external controller reaches it over four wires: an active-low select, a serial clock, a data input and a data output that is driven only while a read returns data. Through this port the controller writes each channel's line-rate mode, datapath bypass, the two clock-edge choices and the buffer-depth choice. It also reads back each channel's buffer-limit flag. The block drives these settings straight to the datapath and gives a one-cycle clear strobe to a channel whenever that channel's status register is read.

Every transaction is a frame of sixteen serial-clock cycles, least significant bit first. The frame holds a direction bit, five address bits, one address bit that must be zero, one ignored bit and eight data bits. All four pins are brought into the block's own clock domain through synchronizer chains, and the frame logic works on the edges it detects there. The serial clock therefore has to run well below the system clock: each half period must last at least the synchronizer depth plus two system cycles.

Top module: `chcfg_serial_port`

## Requirements
- R1: A frame starts when `cs_n` goes low. On each rising `sclk` edge one `sdi` bit is taken. Cycle 1 is the direction (1 = read, 0 = write). Cycles 2 to 6 are address bits 0 to 4, lowest first. Cycle 7 must be 0 for the access to be valid. The value in cycle 8 has no effect.
- R2: In a write, cycles 9 to 16 carry data bits 0 to 7, lowest first. The write takes effect only after the 16th rising edge.
- R3: In a read, `sdo_oe` rises at the falling `sclk` edge of cycle 8 and `sdo` presents data bit 0. Each later falling edge moves on to the next bit, so bit k can be sampled on the rising edge of cycle 9+k.
- R4: `sdo_oe` is low when no frame is active, during write frames, after the falling edge of cycle 16, and within a few system cycles after `cs_n` rises.
- R5: Channel n's configuration register is at address 6 + 8n (0x06, 0x0E, 0x16). Its fields are: bit 5 STS-1 select, bit 4 E3 select, bit 3 bypass, bit 2 output-edge select, bit 1 input-edge select, bit 0 deep-buffer select. Bits 7:6 read back as 0, and each field appears on its own output port.
- R6: Channel n's status register is at address 7 + 8n (0x07, 0x0F, 0x17). Bit 0 holds `lim_flag[n]`, and all other bits read 0.
- R7: Each read of channel n's status register drives `lim_clr[n]` high for exactly one system cycle. No other channel's strobe is driven, and at most one strobe is high in any cycle.
- R8: `cfg_rate[2n+1:2n]` decodes {STS-1, E3} as follows: 00 gives 2'b00 (DS3), 01 gives 2'b01 (E3), 10 gives 2'b10 (STS-1), and 11 gives 2'b01 (E3).
- R9: Reset (`rst_n` low) clears every configuration register to zero.
- R10: Writes to a status address, to an unimplemented address, or with the cycle-7 bit set change no register. Reads from such addresses, other than status addresses, return 0x00.
- R11: Raising `cs_n` before the 16th rising edge ends the frame and commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo; high only while read data is presented |
| lim_flag | input | NCH | Buffer-limit flag level for each channel |
| lim_clr | output | NCH | One-cycle clear strobe for each channel, issued on a status read |
| cfg_rate | output | 2*NCH | Decoded line rate for each channel |
| cfg_bypass | output | NCH | Bypass of the retiming path for each channel |
| cfg_out_edge | output | NCH | Output clock-edge select for each channel |
| cfg_in_edge | output | NCH | Input clock-edge select for each channel |
| cfg_deep | output | NCH | Deep-buffer select for each channel |

## Verification
The bench builds the block with its default parameters: three channels, a channel stride of eight starting at address six, and two synchronizer stages. It drives a serial clock of eight system cycles per half period. These values place every channel's configuration and status address in the 5-bit map, so the highest channel (0x16 and 0x17) and holes in the map between channels (0x05, 0x08) can be tested directly. Two-stage synchronization still leaves each falling edge enough time to update `sdo` before the next rising edge samples it.

// File: rtl/chcfg_pkg.sv
package chcfg_pkg;

   localparam int FRAME_CYCLES = 16;
   localparam int ADDR_BITS    = 5;
   localparam int DATA_BITS    = 8;
   localparam int CNT_BITS     = $clog2(FRAME_CYCLES + 1);
   localparam int CFG_BITS     = 6;

   // Field order matters: sts1 lands in register bit 5, deep in bit 0.
   typedef struct packed {
      logic sts1;
      logic e3;
      logic bypass;
      logic out_edge;
      logic in_edge;
      logic deep;
   } chan_cfg_t;

   typedef enum logic [1:0] {
      RATE_DS3  = 2'b00,
      RATE_E3   = 2'b01,
      RATE_STS1 = 2'b10
   } line_rate_t;

   function automatic line_rate_t decode_rate(input chan_cfg_t c);
      line_rate_t r;
      if (c.e3)        r = RATE_E3;
      else if (c.sts1) r = RATE_STS1;
      else             r = RATE_DS3;
      return r;
   endfunction

endpackage

// File: rtl/chcfg_sync.sv
module chcfg_sync #(
   parameter int               STAGES = 2,
   parameter int               WIDTH  = 1,
   parameter logic [WIDTH-1:0] INIT   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= INIT;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/chcfg_frame.sv
module chcfg_frame
   import chcfg_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n_s,
   input  logic                 sclk_s,
   input  logic                 sdi_s,
   input  logic [DATA_BITS-1:0] rd_data,
   output logic [ADDR_BITS-1:0] addr,
   output logic                 addr_ok,
   output logic                 rd_req,
   output logic                 wr_en,
   output logic [DATA_BITS-1:0] wr_data,
   output logic                 sdo,
   output logic                 sdo_oe
);

   localparam logic [CNT_BITS-1:0] CNT_LAST   = CNT_BITS'(FRAME_CYCLES);
   localparam logic [CNT_BITS-1:0] CNT_ADDR_E = CNT_BITS'(ADDR_BITS);
   localparam logic [CNT_BITS-1:0] CNT_ZERO   = CNT_BITS'(ADDR_BITS + 1);
   localparam logic [CNT_BITS-1:0] CNT_HDR    = CNT_BITS'(ADDR_BITS + 3);

   logic                 sclk_d;
   logic                 rise, fall, cs_act;
   logic [CNT_BITS-1:0]  bit_cnt;
   logic                 rw_q, zero_q;
   logic [ADDR_BITS-1:0] addr_q;
   logic [DATA_BITS-1:0] dat_q;
   logic                 oe_q, sdo_q, rd_req_q, wr_en_q;

   assign cs_act = ~cs_n_s;
   assign rise   = sclk_s & ~sclk_d;
   assign fall   = ~sclk_s & sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   // Header capture, data shift-in and cycle count on rising sclk
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         rw_q     <= 1'b0;
         zero_q   <= 1'b0;
         addr_q   <= '0;
         rd_req_q <= 1'b0;
         wr_en_q  <= 1'b0;
      end else begin
         rd_req_q <= 1'b0;
         wr_en_q  <= 1'b0;
         if (!cs_act) begin
            bit_cnt <= '0;
         end else if (rise && bit_cnt < CNT_LAST) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == '0)
               rw_q <= sdi_s;
            else if (bit_cnt <= CNT_ADDR_E)
               addr_q[3'(bit_cnt - 1'b1)] <= sdi_s;
            else if (bit_cnt == CNT_ZERO)
               zero_q <= sdi_s;
            if (bit_cnt == CNT_HDR - 1'b1 && rw_q)
               rd_req_q <= 1'b1;
            if (bit_cnt == CNT_LAST - 1'b1 && !rw_q)
               wr_en_q <= 1'b1;
         end
      end
   end

   // Data register: shift-in for writes, snapshot for reads
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_q <= '0;
      end else if (rd_req_q) begin
         dat_q <= rd_data;
      end else if (cs_act && rise && !rw_q &&
                   bit_cnt >= CNT_HDR && bit_cnt < CNT_LAST) begin
         dat_q[bit_cnt[2:0]] <= sdi_s;
      end
   end

   // Read-back driver on falling sclk
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q  <= 1'b0;
         sdo_q <= 1'b0;
      end else if (!cs_act) begin
         oe_q  <= 1'b0;
      end else if (fall) begin
         if (bit_cnt == CNT_LAST) begin
            oe_q <= 1'b0;
         end else if (rw_q && bit_cnt >= CNT_HDR) begin
            oe_q  <= 1'b1;
            sdo_q <= dat_q[bit_cnt[2:0]];
         end
      end
   end

   assign addr    = addr_q;
   assign addr_ok = ~zero_q;
   assign rd_req  = rd_req_q;
   assign wr_en   = wr_en_q;
   assign wr_data = dat_q;
   assign sdo     = sdo_q;
   assign sdo_oe  = oe_q;

   // R4: output enable drops once select is released
   a_r4_oe_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !oe_q);

   // R3: the output is enabled only inside a read frame
   a_r3_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      oe_q |-> rw_q);

   // R2/R11: a commit is only ever seen with a completed frame
   a_r11_commit_full: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_q |-> (bit_cnt == CNT_LAST));

endmodule

// File: rtl/chcfg_regbank.sv
module chcfg_regbank
   import chcfg_pkg::*;
#(
   parameter int NCH       = 3,
   parameter int CFG_BASE  = 6,
   parameter int CH_STRIDE = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_BITS-1:0]  addr,
   input  logic                  addr_ok,
   input  logic                  wr_en,
   input  logic [DATA_BITS-1:0]  wr_data,
   input  logic                  rd_req,
   input  logic [NCH-1:0]        lim_flag,
   output logic [DATA_BITS-1:0]  rd_data,
   output chan_cfg_t [NCH-1:0]   cfg,
   output logic [NCH-1:0]        lim_clr
);

   logic [NCH-1:0]       hit_cfg, hit_sts;
   chan_cfg_t [NCH-1:0]  cfg_q;
   logic [NCH-1:0]       clr_q;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
      localparam int A_CFG = CFG_BASE + ch * CH_STRIDE;
      localparam int A_STS = A_CFG + 1;
      assign hit_cfg[ch] = addr_ok && (addr == ADDR_BITS'(A_CFG));
      assign hit_sts[ch] = addr_ok && (addr == ADDR_BITS'(A_STS));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         clr_q <= '0;
      end else begin
         for (int ch = 0; ch < NCH; ch++) begin
            if (wr_en && hit_cfg[ch]) cfg_q[ch] <= wr_data[CFG_BITS-1:0];
            clr_q[ch] <= rd_req && hit_sts[ch];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int ch = 0; ch < NCH; ch++) begin
         if (hit_cfg[ch]) rd_data = rd_data | DATA_BITS'(cfg_q[ch]);
         if (hit_sts[ch]) rd_data = rd_data | DATA_BITS'(lim_flag[ch]);
      end
   end

   assign cfg     = cfg_q;
   assign lim_clr = clr_q;

   // R10: configuration moves only on a committed write to a config address
   a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && |hit_cfg) |=> $stable(cfg_q));

   // R7: never two clear strobes at once
   a_r7_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_q));

   // R7: each strobe lasts a single cycle
   a_r7_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
      |clr_q |=> !(|clr_q));

endmodule

// File: rtl/chcfg_serial_port.sv
module chcfg_serial_port
   import chcfg_pkg::*;
#(
   parameter int NCH         = 3,
   parameter int CFG_BASE    = 6,
   parameter int CH_STRIDE   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             sclk,
   input  logic             sdi,
   output logic             sdo,
   output logic             sdo_oe,
   input  logic [NCH-1:0]   lim_flag,
   output logic [NCH-1:0]   lim_clr,
   output logic [2*NCH-1:0] cfg_rate,
   output logic [NCH-1:0]   cfg_bypass,
   output logic [NCH-1:0]   cfg_out_edge,
   output logic [NCH-1:0]   cfg_in_edge,
   output logic [NCH-1:0]   cfg_deep
);

   localparam int TOP_ADDR = CFG_BASE + (NCH - 1) * CH_STRIDE + 1;

   if (NCH < 1) begin : g_bad_nch
      $error("chcfg_serial_port: NCH must be at least 1");
   end
   if (CH_STRIDE < 2) begin : g_bad_stride
      $error("chcfg_serial_port: CH_STRIDE must leave room for the status register");
   end
   if (TOP_ADDR >= (1 << ADDR_BITS)) begin : g_bad_map
      $error("chcfg_serial_port: register map exceeds the address field");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("chcfg_serial_port: SYNC_STAGES must be at least 2");
   end

   logic [2:0]           pins_s;
   logic                 cs_n_s, sclk_s, sdi_s;
   logic [ADDR_BITS-1:0] addr;
   logic                 addr_ok, rd_req, wr_en;
   logic [DATA_BITS-1:0] wr_data, rd_data;
   chan_cfg_t [NCH-1:0]  cfg;

   chcfg_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (3),
      .INIT   (3'b001)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sdi, sclk, cs_n}),
      .q     (pins_s)
   );

   assign cs_n_s = pins_s[0];
   assign sclk_s = pins_s[1];
   assign sdi_s  = pins_s[2];

   chcfg_frame u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n_s  (cs_n_s),
      .sclk_s  (sclk_s),
      .sdi_s   (sdi_s),
      .rd_data (rd_data),
      .addr    (addr),
      .addr_ok (addr_ok),
      .rd_req  (rd_req),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .sdo     (sdo),
      .sdo_oe  (sdo_oe)
   );

   chcfg_regbank #(
      .NCH       (NCH),
      .CFG_BASE  (CFG_BASE),
      .CH_STRIDE (CH_STRIDE)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (addr),
      .addr_ok  (addr_ok),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_req   (rd_req),
      .lim_flag (lim_flag),
      .rd_data  (rd_data),
      .cfg      (cfg),
      .lim_clr  (lim_clr)
   );

   for (genvar ch = 0; ch < NCH; ch++) begin : g_out
      assign cfg_rate[2*ch +: 2] = decode_rate(cfg[ch]);
      assign cfg_bypass[ch]      = cfg[ch].bypass;
      assign cfg_out_edge[ch]    = cfg[ch].out_edge;
      assign cfg_in_edge[ch]     = cfg[ch].in_edge;
      assign cfg_deep[ch]        = cfg[ch].deep;

      // R8: the reserved code 2'b11 never reaches a channel
      a_r8_rate_legal: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_rate[2*ch +: 2] != 2'b11);
   end

endmodule

// File: tb/chcfg_serial_port_bench.sv
`timescale 1ns/100ps
module chcfg_serial_port_bench;

   localparam int  NCH  = 3;
   localparam real HALF = 40.0;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cs_n = 1'b1;
   logic           sclk = 1'b0;
   logic           sdi = 1'b0;
   logic           sdo, sdo_oe;
   logic [NCH-1:0] lim_flag = '0;
   logic [NCH-1:0] lim_clr;
   logic [2*NCH-1:0] cfg_rate;
   logic [NCH-1:0] cfg_bypass, cfg_out_edge, cfg_in_edge, cfg_deep;

   int checks = 0;
   int errors = 0;
   int clr_cnt [NCH];
   logic [7:0] rdata;
   bit         oe_all, oe_any;

   always #2.5 clk = ~clk;

   chcfg_serial_port u_chcfg_serial_port (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_n         (cs_n),
      .sclk         (sclk),
      .sdi          (sdi),
      .sdo          (sdo),
      .sdo_oe       (sdo_oe),
      .lim_flag     (lim_flag),
      .lim_clr      (lim_clr),
      .cfg_rate     (cfg_rate),
      .cfg_bypass   (cfg_bypass),
      .cfg_out_edge (cfg_out_edge),
      .cfg_in_edge  (cfg_in_edge),
      .cfg_deep     (cfg_deep)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NCH; k++) clr_cnt[k] <= 0;
      end else begin
         for (int k = 0; k < NCH; k++) if (lim_clr[k]) clr_cnt[k] <= clr_cnt[k] + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // One serial frame; nbits < 16 aborts it by raising the select early
   task automatic xfer(input bit rd, input logic [6:0] a7, input logic [7:0] wd,
                       input int nbits);
      rdata  = '0;
      oe_all = 1'b1;
      oe_any = 1'b0;
      cs_n = 1'b0;
      #(HALF);
      for (int i = 0; i < nbits; i++) begin
         if (i == 0)     sdi = rd;
         else if (i < 8) sdi = a7[i-1];
         else            sdi = wd[i-8];
         #(HALF);
         if (i >= 8) begin
            rdata[i-8] = sdo;
            oe_all = oe_all & sdo_oe;
         end
         oe_any = oe_any | sdo_oe;
         sclk = 1'b1;
         #(HALF);
         sclk = 1'b0;
      end
      #(HALF);
   endtask

   task automatic end_frame();
      cs_n = 1'b1;
      sdi  = 1'b0;
      #(HALF * 2);
   endtask

   task automatic wr(input logic [6:0] a7, input logic [7:0] d);
      xfer(1'b0, a7, d, 16);
      end_frame();
   endtask

   task automatic rd(input logic [6:0] a7);
      xfer(1'b1, a7, 8'h00, 16);
      end_frame();
   endtask

   task automatic t_reset();
      chk("R9 reset bypass", cfg_bypass, '0);
      chk("R9 reset rate", cfg_rate, '0);
      chk("R9 reset deep/edges", {cfg_deep, cfg_in_edge, cfg_out_edge}, '0);
      chk("R4 oe low idle", sdo_oe, 1'b0);
      chk("R7 no strobe at reset", lim_clr, '0);
   endtask

   task automatic t_write_read();
      wr(7'h06, 8'h3F);
      chk("R4 oe low in write", oe_any, 1'b0);
      rd(7'h06);
      chk("R3 read ch0", rdata, 8'h3F);
      chk("R3 oe through data", oe_all, 1'b1);
      chk("R5 ch0 fields", {cfg_bypass[0], cfg_out_edge[0], cfg_in_edge[0], cfg_deep[0]}, 4'hF);
      wr(7'h0E, 8'hE5);
      rd(7'h0E);
      chk("R5 ch1 upper bits read zero", rdata, 8'h25);
      chk("R2 ch1 fields", {cfg_bypass[1], cfg_out_edge[1], cfg_in_edge[1], cfg_deep[1]}, 4'b0101);
      chk("R8 ch1 sts1", cfg_rate[3:2], 2'b10);
      wr(7'h16, 8'h1A);
      rd(7'h16);
      chk("R1 ch2 read", rdata, 8'h1A);
      chk("R5 ch2 fields", {cfg_bypass[2], cfg_out_edge[2], cfg_in_edge[2], cfg_deep[2]}, 4'b1010);
      chk("R8 ch2 e3", cfg_rate[5:4], 2'b01);
      chk("R5 ch0 undisturbed", cfg_rate[1:0], 2'b01);
   endtask

   task automatic t_rate();
      logic [1:0] exp [4] = '{2'b00, 2'b01, 2'b10, 2'b01};
      for (int m = 0; m < 4; m++) begin
         wr(7'h06, 8'(m << 4));
         chk($sformatf("R8 mode %0d", m), cfg_rate[1:0], exp[m]);
      end
   endtask

   task automatic t_status();
      lim_flag = 3'b101;
      rd(7'h07);
      chk("R6 ch0 flag", rdata, 8'h01);
      chk("R7 ch0 strobe", clr_cnt[0], 1);
      chk("R7 others quiet", clr_cnt[1] + clr_cnt[2], 0);
      rd(7'h0F);
      chk("R6 ch1 flag clear", rdata, 8'h00);
      chk("R7 ch1 strobe", clr_cnt[1], 1);
      rd(7'h17);
      chk("R6 ch2 flag", rdata, 8'h01);
      chk("R7 ch2 strobe", clr_cnt[2], 1);
      chk("R7 ch0 single", clr_cnt[0], 1);
   endtask

   task automatic t_ignored();
      wr(7'h06, 8'h2C);
      wr(7'h07, 8'hFF);
      wr(7'h05, 8'hFF);
      wr(7'h26, 8'h00);
      chk("R10 ch0 kept", {cfg_rate[1:0], cfg_bypass[0], cfg_out_edge[0], cfg_deep[0]}, 5'b10110);
      rd(7'h06);
      chk("R10 ch0 readback", rdata, 8'h2C);
      rd(7'h05);
      chk("R10 hole 0x05 reads 0", rdata, 8'h00);
      rd(7'h08);
      chk("R10 hole 0x08 reads 0", rdata, 8'h00);
      rd(7'h26);
      chk("R10 cycle7 set reads 0", rdata, 8'h00);
      wr(7'h46, 8'h11);
      rd(7'h06);
      chk("R1 cycle8 ignored", rdata, 8'h11);
   endtask

   task automatic t_abort();
      xfer(1'b0, 7'h06, 8'h00, 15);
      end_frame();
      rd(7'h06);
      chk("R11 aborted write", rdata, 8'h11);
      xfer(1'b1, 7'h06, 8'h00, 16);
      chk("R4 oe off after cycle 16", sdo_oe, 1'b0);
      end_frame();
      xfer(1'b1, 7'h06, 8'h00, 12);
      chk("R3 oe on mid read", sdo_oe, 1'b1);
      end_frame();
      chk("R4 oe off after abort", sdo_oe, 1'b0);
   endtask

   task automatic t_reset_mid();
      #3 rst_n = 1'b0;
      #20 rst_n = 1'b1;
      #40;
      chk("R9 reset clears rate", cfg_rate, '0);
      chk("R9 reset clears bits", {cfg_bypass, cfg_out_edge, cfg_in_edge, cfg_deep}, '0);
      rd(7'h16);
      chk("R9 ch2 reads 0", rdata, 8'h00);
   endtask

   initial begin
      #100;
      t_reset();
      rst_n = 1'b1;
      #100;
      t_write_read();
      t_rate();
      t_status();
      t_ignored();
      t_abort();
      t_reset_mid();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #500000;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule